// File: doc/BRIEF.md
# Multi-Channel Gamma Lookup Table with Auto-Increment Loader

This block applies a per-component tone curve to the pixel streams of several display channels. All curves live in one shared table memory. Each channel owns three consecutive slices of that memory, one each for red, green and blue, and every slice has one entry per possible component value. A channel with its gamma enable set replaces each incoming component with the table entry that the component value selects. A channel with its gamma enable clear passes its pixels through unchanged. Both paths have the same one-cycle latency, and the valid and sync flags are delayed to stay aligned with the pixels.

Software fills the table through a two-register write port. The address register holds the current table pointer, an auto-increment flag and a force-on flag. Each write to the data register stores one entry at the pointer, and the pointer then advances if auto-increment is set. The table memory is powered only while at least one channel uses gamma or the force-on flag is set. When it powers down, its contents are lost and are modelled as zero. Software must therefore reload the curves after such a gap, or hold the force-on flag across it.

Top module: `gamma_lut_top`

## Requirements
- R1: The entry for channel c, component k (0 = red, 1 = green, 2 = blue) and component value v sits at table address (c*3 + k) * 2^CW + v. With CW=8, channel c starts at c*768.
- R2: When reg_wr is high and reg_sel is 1 (data register), the table stores reg_wdata[CW-1:0] at the current pointer on the next clock edge, provided the memory is powered.
- R3: With auto-increment set, each data-register write advances the pointer by one. With it clear, the pointer stays put and repeated data writes overwrite the same entry.
- R4: Auto-increment from the last table address (NCH*3*2^CW - 1) wraps the pointer to 0.
- R5: When reg_wr is high and reg_sel is 0 (address register), the pointer loads from reg_wdata[AW-1:0], auto-increment loads from bit 31 and force-on loads from bit 30. AW is the bit count needed to address the whole table: 12 for the defaults.
- R6: For a channel whose enable is set, the output red, green and blue are the table entries of R1 indexed by the input components, one clock cycle after the input.
- R7: For a channel whose enable is clear, the output pixel equals the input pixel one clock cycle later.
- R8: out_valid, out_hsync and out_vsync of each channel equal the corresponding inputs one clock cycle earlier.
- R9: The memory is powered while any chan_gamma_en bit or the force-on flag is set. With force-on set and every channel disabled, the table contents are retained.
- R10: While the memory is unpowered, every entry is cleared to zero and data writes are discarded, but the pointer still auto-increments on each data write.
- R11: During reset, all outputs are zero, and the pointer and both flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 address register, 1 data register |
| reg_wdata | input | 32 | Register write data |
| chan_gamma_en | input | NCH | Per-channel gamma enable |
| in_valid | input | NCH | Per-channel input pixel valid |
| in_hsync | input | NCH | Per-channel input horizontal sync |
| in_vsync | input | NCH | Per-channel input vertical sync |
| in_pix | input | NCH*3*CW | Input pixels; channel c at [c*3*CW +: 3*CW]; red lowest, then green, then blue |
| out_valid | output | NCH | Delayed valid |
| out_hsync | output | NCH | Delayed horizontal sync |
| out_vsync | output | NCH | Delayed vertical sync |
| out_pix | output | NCH*3*CW | Corrected or passed-through pixels, packed like in_pix |

## Verification
The bench builds the block with its defaults, NCH=3 and CW=8, which gives a 2304-entry table. That size is small enough to load every entry with an arithmetic pattern through the auto-increment port, and then to sweep all 256 component values on all three channels. The same configuration brings the table's last address within reach, so the pointer wrap can be tested. It also allows the channel enables to be switched between full lookup, mixed pass-through, forced retention and power-off clearing. After each of these switches, the bench reads the effect back through the pixel outputs.

// File: rtl/gtab_pkg.sv
package gtab_pkg;
   localparam int unsigned COMPS      = 3;
   localparam int unsigned AUTOINC_BIT = 31;
   localparam int unsigned FORCE_BIT   = 30;

   typedef enum logic {
      SEL_ADDR = 1'b0,
      SEL_DATA = 1'b1
   } reg_sel_e;

   // first table address of one colour slice of one channel
   function automatic int unsigned slice_base(int unsigned ch, int unsigned comp,
                                              int unsigned cw);
      return (ch * COMPS + comp) << cw;
   endfunction
endpackage

// File: rtl/gtab_addr_port.sv
module gtab_addr_port #(
   parameter int unsigned AW    = 12,
   parameter int unsigned DEPTH = 2304
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_sel,
   input  logic [31:0]   reg_wdata,
   output logic [AW-1:0] cur_addr,
   output logic          auto_inc,
   output logic          force_on,
   output logic          data_wr
);
   import gtab_pkg::*;

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic addr_wr;

   assign addr_wr = reg_wr && (reg_sel_e'(reg_sel) == SEL_ADDR);
   assign data_wr = reg_wr && (reg_sel_e'(reg_sel) == SEL_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         auto_inc <= 1'b0;
         force_on <= 1'b0;
      end else if (addr_wr) begin
         cur_addr <= reg_wdata[AW-1:0];
         auto_inc <= reg_wdata[AUTOINC_BIT];
         force_on <= reg_wdata[FORCE_BIT];
      end else if (data_wr && auto_inc) begin
         cur_addr <= (cur_addr >= LAST) ? '0 : cur_addr + 1'b1;
      end
   end
endmodule

// File: rtl/gtab_store.sv
module gtab_store #(
   parameter int unsigned CW    = 8,
   parameter int unsigned DEPTH = 2304,
   parameter int unsigned AW    = 12,
   parameter int unsigned NRD   = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              power_on,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [CW-1:0]     wr_data,
   input  logic [NRD*AW-1:0] rd_addr,
   output logic [NRD*CW-1:0] rd_data
);
   localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

   logic [CW-1:0] mem [DEPTH];
   logic          wr_in_range;

   assign wr_in_range = ({1'b0, wr_addr} < DEPTH_W);

   // contents are lost whenever power is removed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      end else if (!power_on) begin
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      end else if (wr_en && wr_in_range) begin
         mem[wr_addr] <= wr_data;
      end
   end

   for (genvar r = 0; r < int'(NRD); r++) begin : g_rd
      logic [AW-1:0] ra;
      assign ra = rd_addr[r*AW +: AW];
      assign rd_data[r*CW +: CW] =
         (power_on && ({1'b0, ra} < DEPTH_W)) ? mem[ra] : '0;
   end
endmodule

// File: rtl/gtab_chan.sv
module gtab_chan #(
   parameter int unsigned CW     = 8,
   parameter int unsigned AW     = 12,
   parameter int unsigned CH_IDX = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            gamma_en,
   input  logic            in_valid,
   input  logic            in_hsync,
   input  logic            in_vsync,
   input  logic [3*CW-1:0] in_pix,
   input  logic [3*CW-1:0] lut_val,
   output logic [3*AW-1:0] lut_addr,
   output logic            out_valid,
   output logic            out_hsync,
   output logic            out_vsync,
   output logic [3*CW-1:0] out_pix
);
   import gtab_pkg::*;

   for (genvar k = 0; k < int'(COMPS); k++) begin : g_comp
      localparam logic [AW-1:0] BASE = AW'(slice_base(CH_IDX, k, CW));
      assign lut_addr[k*AW +: AW] = BASE + AW'(in_pix[k*CW +: CW]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_hsync <= 1'b0;
         out_vsync <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= in_valid;
         out_hsync <= in_hsync;
         out_vsync <= in_vsync;
         out_pix   <= gamma_en ? lut_val : in_pix;
      end
   end
endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top #(
   parameter int unsigned NCH = 3,
   parameter int unsigned CW  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_sel,
   input  logic [31:0]         reg_wdata,
   input  logic [NCH-1:0]      chan_gamma_en,
   input  logic [NCH-1:0]      in_valid,
   input  logic [NCH-1:0]      in_hsync,
   input  logic [NCH-1:0]      in_vsync,
   input  logic [NCH*3*CW-1:0] in_pix,
   output logic [NCH-1:0]      out_valid,
   output logic [NCH-1:0]      out_hsync,
   output logic [NCH-1:0]      out_vsync,
   output logic [NCH*3*CW-1:0] out_pix
);
   import gtab_pkg::*;

   localparam int unsigned SLICE = 1 << CW;
   localparam int unsigned DEPTH = NCH * COMPS * SLICE;
   localparam int unsigned AW    = $clog2(DEPTH);
   localparam int unsigned NRD   = NCH * COMPS;

   if (NCH < 1 || NCH > 4) begin : g_bad_nch
      $error("gamma_lut_top: NCH must lie in 1..4");
   end
   if (CW < 1 || CW > 10) begin : g_bad_cw
      $error("gamma_lut_top: CW must lie in 1..10");
   end
   if (AW > FORCE_BIT) begin : g_bad_aw
      $error("gamma_lut_top: pointer field overlaps the flag bits");
   end

   logic [AW-1:0]     cur_addr;
   logic              auto_inc;
   logic              force_on;
   logic              data_wr;
   logic              power_on;
   logic [NRD*AW-1:0] rd_addr;
   logic [NRD*CW-1:0] rd_data;

   assign power_on = (|chan_gamma_en) | force_on;

   gtab_addr_port #(.AW(AW), .DEPTH(DEPTH)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_sel  (reg_sel),
      .reg_wdata(reg_wdata),
      .cur_addr (cur_addr),
      .auto_inc (auto_inc),
      .force_on (force_on),
      .data_wr  (data_wr)
   );

   gtab_store #(.CW(CW), .DEPTH(DEPTH), .AW(AW), .NRD(NRD)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .power_on(power_on),
      .wr_en   (data_wr),
      .wr_addr (cur_addr),
      .wr_data (reg_wdata[CW-1:0]),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   for (genvar c = 0; c < int'(NCH); c++) begin : g_ch
      gtab_chan #(.CW(CW), .AW(AW), .CH_IDX(c)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .gamma_en (chan_gamma_en[c]),
         .in_valid (in_valid[c]),
         .in_hsync (in_hsync[c]),
         .in_vsync (in_vsync[c]),
         .in_pix   (in_pix[c*3*CW +: 3*CW]),
         .lut_val  (rd_data[c*3*CW +: 3*CW]),
         .lut_addr (rd_addr[c*3*AW +: 3*AW]),
         .out_valid(out_valid[c]),
         .out_hsync(out_hsync[c]),
         .out_vsync(out_vsync[c]),
         .out_pix  (out_pix[c*3*CW +: 3*CW])
      );
   end
endmodule

// File: rtl/gtab_checker.sv
module gtab_checker #(
   parameter int unsigned NCH = 3,
   parameter int unsigned CW  = 8,
   parameter int unsigned AW  = 12,
   parameter int unsigned DEPTH = 2304
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NCH-1:0]      chan_gamma_en,
   input logic [NCH-1:0]      in_valid,
   input logic [NCH-1:0]      in_hsync,
   input logic [NCH-1:0]      in_vsync,
   input logic [NCH*3*CW-1:0] in_pix,
   input logic [NCH-1:0]      out_valid,
   input logic [NCH-1:0]      out_hsync,
   input logic [NCH-1:0]      out_vsync,
   input logic [NCH*3*CW-1:0] out_pix,
   input logic                power_on,
   input logic [AW-1:0]       cur_addr,
   input logic                auto_inc,
   input logic                data_wr,
   input logic [CW-1:0]       first_entry
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   p_flag_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (out_valid == $past(in_valid)) && (out_hsync == $past(in_hsync))
                  && (out_vsync == $past(in_vsync)));

   for (genvar c = 0; c < int'(NCH); c++) begin : g_pt
      p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && !$past(chan_gamma_en[c])) |->
            (out_pix[c*3*CW +: 3*CW] == $past(in_pix[c*3*CW +: 3*CW])));
   end

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && auto_inc && cur_addr < LAST) |=> (cur_addr == $past(cur_addr) + 1'b1));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !auto_inc) |=> $stable(cur_addr));

   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && auto_inc && cur_addr >= LAST) |=> (cur_addr == '0));

   p_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !power_on |=> (first_entry == '0));
endmodule

bind gamma_lut_top gtab_checker #(.NCH(NCH), .CW(CW), .AW(AW), .DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .chan_gamma_en(chan_gamma_en),
   .in_valid     (in_valid),
   .in_hsync     (in_hsync),
   .in_vsync     (in_vsync),
   .in_pix       (in_pix),
   .out_valid    (out_valid),
   .out_hsync    (out_hsync),
   .out_vsync    (out_vsync),
   .out_pix      (out_pix),
   .power_on     (power_on),
   .cur_addr     (cur_addr),
   .auto_inc     (auto_inc),
   .data_wr      (data_wr),
   .first_entry  (u_store.mem[0])
);

// File: tb/sim_gamma_lut_top.sv
module sim_gamma_lut_top;
   localparam int NCH   = 3;
   localparam int CW    = 8;
   localparam int SL    = 256;
   localparam int DEPTH = NCH * 3 * SL;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic                reg_wr = 1'b0;
   logic                reg_sel = 1'b0;
   logic [31:0]         reg_wdata = '0;
   logic [NCH-1:0]      en = '0;
   logic [NCH-1:0]      iv = '0, ih = '0, ivs = '0;
   logic [NCH*3*CW-1:0] ip = '0;
   logic [NCH-1:0]      ov, oh, ovs;
   logic [NCH*3*CW-1:0] op;

   gamma_lut_top #(.NCH(NCH), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .chan_gamma_en(en), .in_valid(iv),
      .in_hsync(ih), .in_vsync(ivs), .in_pix(ip), .out_valid(ov),
      .out_hsync(oh), .out_vsync(ovs), .out_pix(op)
   );

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [7:0] model [DEPTH];

   function automatic logic [7:0] pattern(int j);
      int c = j / (3 * SL);
      int k = (j / SL) % 3;
      int i = j % SL;
      return 8'((i * 37 + c * 101 + k * 59 + 13) & 255);
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr_reg(bit sel, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // drive one pixel on every channel, then compare one cycle later
   task automatic pix(int i, string req);
      int v [3];
      v[0] = i & 255; v[1] = (i * 3 + 1) & 255; v[2] = 255 - (i & 255);
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
         for (int k = 0; k < 3; k++) ip[(c*3+k)*CW +: CW] = 8'(v[k]);
      end
      iv = '1; ih = {NCH{i[0]}}; ivs = {NCH{i[1]}};
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
         for (int k = 0; k < 3; k++) begin
            int exp = en[c] ? int'(model[(c*3+k)*SL + v[k]]) : v[k];
            int act = int'(op[(c*3+k)*CW +: CW]);
            chk(act == exp, req, $sformatf("ch%0d comp%0d in=%0d", c, k, v[k]), act, exp);
         end
      end
      chk(ov == '1 && oh == {NCH{i[0]}} && ovs == {NCH{i[1]}}, "R8", "flags",
          int'({ov, oh, ovs}), int'({{NCH{1'b1}}, {NCH{i[0]}}, {NCH{i[1]}}}));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R11: outputs held at zero in reset despite active inputs
      iv = '1; ih = '1; ivs = '1; ip = '1;
      repeat (3) @(negedge clk);
      chk(op == '0 && ov == '0 && oh == '0 && ovs == '0, "R11", "reset outputs",
          int'(op[31:0]), 0);
      iv = '0; ih = '0; ivs = '0; ip = '0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(op == '0 && ov == '0, "R11", "after release", int'(op[31:0]), 0);

      // R1 R2 R3 R5: load whole table through auto-increment with force-on
      wr_reg(1'b0, 32'hC000_0000);
      for (int j = 0; j < DEPTH; j++) begin
         model[j] = pattern(j);
         wr_reg(1'b1, {24'hABCDEF, pattern(j)});
      end

      // R6: all channels looked up over every component value
      en = '1;
      for (int i = 0; i < SL; i++) pix(i, "R6");

      // R7: channel 1 bypassed, others looked up
      en = 3'b101;
      for (int i = 0; i < SL; i++) pix(i, "R7");
      en = '1;

      // R3: pointer held without auto-increment (address 5, force on)
      wr_reg(1'b0, 32'h4000_0005);
      wr_reg(1'b1, 32'h0000_00AA);
      wr_reg(1'b1, 32'h0000_003C);
      model[5] = 8'h3C;
      pix(5, "R3");
      pix(6, "R3");

      // R4: wrap from the last address to zero
      wr_reg(1'b0, 32'hC000_0000 | (DEPTH - 1));
      wr_reg(1'b1, 32'h0000_0011);
      wr_reg(1'b1, 32'h0000_0022);
      model[DEPTH-1] = 8'h11;
      model[0] = 8'h22;
      pix(0, "R4");
      pix(255, "R4");

      // R9: force-on keeps contents while every channel is disabled
      wr_reg(1'b0, 32'h4000_0000);
      en = '0;
      repeat (5) @(negedge clk);
      en = '1;
      pix(0, "R9");
      pix(77, "R9");

      // R10: power removed, writes discarded, pointer still advances
      wr_reg(1'b0, 32'h8000_0000);
      en = '0;
      repeat (3) @(negedge clk);
      for (int j = 0; j < DEPTH; j++) model[j] = 8'h00;
      pix(9, "R10");
      wr_reg(1'b1, 32'h0000_0077);
      wr_reg(1'b1, 32'h0000_0077);
      wr_reg(1'b1, 32'h0000_0077);
      en = '1;
      wr_reg(1'b1, 32'h0000_0099);
      model[3] = 8'h99;
      pix(0, "R10");
      pix(1, "R10");
      pix(3, "R10");
      pix(200, "R10");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule